// File: doc/BRIEF.md
# IR Carrier Period Window Detector

This block decides whether a demodulated infrared carrier has an acceptable frequency. It takes a synchronised digital carrier from the photodetector path and measures the time between successive rising edges in master-clock cycles. It then tests each measured period against an acceptance window. A programmed divider count sets the nominal period. A 4-bit sensitivity setting sets how far below that count a period may fall. The window reaches only one cycle above the divider count and many cycles below it. To centre a wanted frequency, software therefore programs the divider somewhat longer than the nominal period.

Every accepted period produces a one-cycle `carrier_ok_o` pulse. The `envelope_o` output reports light versus no light. It rises with the first accepted period and stays high while accepted periods follow one another. It falls when a period lands outside the window, or when no edge arrives within the longest acceptable period. With a 3.6864 MHz master clock, a divider of 105 and sensitivity 8, the block accepts roughly 34.8 kHz to 41.9 kHz, which centres a 38 kHz carrier.

Top module: `ir_carrier_window`

## Requirements
- R1: A rising edge is `carrier_i` low in one cycle and high in the next. The measured period is the number of clock cycles from one rising edge to the next.
- R2: The first rising edge after reset, or after an envelope timeout, only sets a reference. It produces no `carrier_ok_o` pulse.
- R3: A measured period P is accepted when `period_i - (2*sens_i + 1) <= P <= period_i + 1`. Each accepted period gives a `carrier_ok_o` pulse exactly one cycle wide, in the cycle after the completing rising edge.
- R4: With `period_i` = 105 and `sens_i` = 8, periods 88 and 106 are accepted and periods 87 and 107 are rejected.
- R5: With `sens_i` = 0 (the tightest window), `period_i` = 40 accepts 39 and 41 and rejects 38.
- R6: `envelope_o` rises together with the `carrier_ok_o` pulse of an accepted period. It stays high through following accepted periods.
- R7: A rising edge that completes an out-of-window period clears `envelope_o` in the next cycle and gives no pulse. That edge becomes the new reference, so a valid period measured from it raises `envelope_o` again.
- R8: Let k be the cycle of the last rising edge, with no further edge. `envelope_o` is still high in cycle k + `period_i` + 2 and is low from cycle k + `period_i` + 3 on.
- R9: While `rst_ni` is low, and right after it is released, `carrier_ok_o` and `envelope_o` are low.
- R10: When the offset exceeds `period_i`, the lower bound saturates at zero. With `period_i` = 5 and `sens_i` = 15, a period of 2 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; periods are counted in its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Synchronised demodulated carrier level |
| period_i | input | PER_W (12) | Divider count: nominal carrier period in clock cycles |
| sens_i | input | 4 | Timing sensitivity; selects the lower window offset 2*sens_i+1 |
| carrier_ok_o | output | 1 | One-cycle pulse for each period inside the window |
| envelope_o | output | 1 | High while consecutive carrier periods are valid |

## Verification
A wrong period count or a wrong window bound appears at the ports in the cycle after the edge that completes the period. It shows as a missing or extra `carrier_ok_o` pulse at the exact window boundaries, one cycle inside and one outside each bound. A stuck reference flag shows on the first edge after reset or timeout, as a pulse where none belongs. A wrong timeout threshold moves the fall of `envelope_o` by at least one cycle against the expected cycle k + `period_i` + 3. The stimulus probes that single-cycle boundary directly.

// File: rtl/ir_cw_pkg.sv
package ir_cw_pkg;
  localparam int unsigned SENS_W = 4;
  localparam int unsigned SENS_N = 1 << SENS_W;
  localparam int unsigned OFF_BASE = 1;   // offset at sensitivity 0
  localparam int unsigned OFF_STEP = 2;   // extra cycles per sensitivity step
  localparam int unsigned UP_MARGIN = 1;  // cycles accepted above divider count
endpackage

// File: rtl/ir_cw_edge.sv
module ir_cw_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b1;  // no edge seen right out of reset with input high
    else         level_q <= sig_i;
  end

  assign rise_o = sig_i & ~level_q;
endmodule

// File: rtl/ir_cw_period_cnt.sv
module ir_cw_period_cnt #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= CNT_W'(1);
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ir_cw_window.sv
module ir_cw_window
  import ir_cw_pkg::*;
#(
  parameter int unsigned PER_W = 12,
  parameter int unsigned CNT_W = PER_W + 1
) (
  input  logic [PER_W-1:0]  period_i,
  input  logic [SENS_W-1:0] sens_i,
  input  logic [CNT_W-1:0]  meas_i,
  output logic              in_win_o,
  output logic              over_o
);
  logic [CNT_W-1:0] off_tbl [SENS_N];

  // offset lookup, one entry per sensitivity step
  for (genvar s = 0; s < SENS_N; s++) begin : g_off
    assign off_tbl[s] = CNT_W'(OFF_BASE + OFF_STEP * s);
  end

  logic [CNT_W-1:0] per_ext, off_sel, lo_bound, hi_bound;

  always_comb begin
    per_ext  = CNT_W'(period_i);
    off_sel  = off_tbl[sens_i];
    lo_bound = (per_ext > off_sel) ? per_ext - off_sel : '0;
    hi_bound = per_ext + CNT_W'(UP_MARGIN);
  end

  assign over_o   = meas_i > hi_bound;
  assign in_win_o = (meas_i >= lo_bound) && !over_o;
endmodule

// File: rtl/ir_carrier_window.sv
module ir_carrier_window
  import ir_cw_pkg::*;
#(
  parameter int unsigned PER_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carrier_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [SENS_W-1:0] sens_i,
  output logic              carrier_ok_o,
  output logic              envelope_o
);
  localparam int unsigned CNT_W = PER_W + 1;

  logic             rise;
  logic [CNT_W-1:0] meas;
  logic             in_win, over;
  logic             armed_q, env_q, ok_q;
  logic             good_per, bad_per, timeout;

  ir_cw_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (carrier_i),
    .rise_o (rise)
  );

  ir_cw_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rise),
    .cnt_o     (meas)
  );

  ir_cw_window #(.PER_W(PER_W), .CNT_W(CNT_W)) u_win (
    .period_i (period_i),
    .sens_i   (sens_i),
    .meas_i   (meas),
    .in_win_o (in_win),
    .over_o   (over)
  );

  always_comb begin
    good_per = rise & armed_q & in_win;
    bad_per  = rise & armed_q & ~in_win;
    timeout  = ~rise & armed_q & over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      env_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      ok_q <= good_per;
      if (rise)         armed_q <= 1'b1;
      else if (timeout) armed_q <= 1'b0;
      if (good_per)                env_q <= 1'b1;
      else if (bad_per || timeout) env_q <= 1'b0;
    end
  end

  assign carrier_ok_o = ok_q;
  assign envelope_o   = env_q;
endmodule

// File: rtl/ir_cw_checker.sv
module ir_cw_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic carrier_i,
  input logic carrier_ok_o,
  input logic envelope_o
);
  AST_OK_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_ok_o |-> ($past(carrier_i) && !$past(carrier_i, 2))); // R1

  AST_OK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_ok_o |=> !carrier_ok_o); // R3

  AST_OK_IMPLIES_ENV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_ok_o |-> envelope_o); // R6

  AST_ENV_RISE_WITH_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(envelope_o) |-> carrier_ok_o); // R6

  AST_ENV_FALL_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(envelope_o) |-> !carrier_ok_o); // R7
endmodule

bind ir_carrier_window ir_cw_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .carrier_i    (carrier_i),
  .carrier_ok_o (carrier_ok_o),
  .envelope_o   (envelope_o)
);

// File: tb/ir_carrier_window_tb_top.sv
module ir_carrier_window_tb_top;
  localparam int PER_W = 12;

  typedef struct packed {
    logic [11:0] div;
    logic [3:0]  sens;
    logic [15:0] per;
    logic [3:0]  n;
    logic [3:0]  exp_ok;
    logic        exp_env;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{12'd105, 4'd8,  16'd88,  4'd3, 4'd3, 1'b1},  // R4 low edge in
    '{12'd105, 4'd8,  16'd87,  4'd3, 4'd0, 1'b0},  // R4 low edge out
    '{12'd105, 4'd8,  16'd106, 4'd3, 4'd3, 1'b1},  // R4 high edge in
    '{12'd105, 4'd8,  16'd107, 4'd3, 4'd0, 1'b0},  // R4 high edge out
    '{12'd40,  4'd0,  16'd39,  4'd2, 4'd2, 1'b1},  // R5
    '{12'd40,  4'd0,  16'd38,  4'd2, 4'd0, 1'b0},  // R5
    '{12'd40,  4'd0,  16'd41,  4'd2, 4'd2, 1'b1},  // R5
    '{12'd40,  4'd15, 16'd9,   4'd2, 4'd2, 1'b1},  // R3 widest window
    '{12'd40,  4'd15, 16'd8,   4'd2, 4'd0, 1'b0},  // R3
    '{12'd5,   4'd15, 16'd2,   4'd3, 4'd3, 1'b1},  // R10
    '{12'd40,  4'd3,  16'd40,  4'd0, 4'd0, 1'b0}   // R2 single edge
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             carrier = 1'b0;
  logic [PER_W-1:0] div = '0;
  logic [3:0]       sens = '0;
  logic             ok, env;
  int checks = 0, fails = 0, ok_cnt = 0;

  always #5 clk = ~clk;

  ir_carrier_window #(.PER_W(PER_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .carrier_i    (carrier),
    .period_i     (div),
    .sens_i       (sens),
    .carrier_ok_o (ok),
    .envelope_o   (env)
  );

  always @(negedge clk) if (ok) ok_cnt++;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(posedge clk); #1 carrier = v;
  endtask

  task automatic smp;
    @(negedge clk); #2;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; carrier = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) drive(1'b0);
    ok_cnt = 0;
  endtask

  // n+1 rising edges spaced p cycles; ends one cycle after last edge
  task automatic emit(input int p, input int n);
    drive(1'b1);
    for (int i = 0; i < n; i++) begin
      for (int j = 1; j < p; j++) drive(1'b0);
      drive(1'b1);
    end
    drive(1'b0);
    smp();
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    // R9 reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    smp();
    chk(!ok && !env, "R9 in reset", {ok, env}, 0);
    do_reset();
    smp();
    chk(!ok && !env, "R9 after release", {ok, env}, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      div = VEC[v].div; sens = VEC[v].sens;
      drive(1'b0);
      ok_cnt = 0;
      emit(int'(VEC[v].per), int'(VEC[v].n));
      chk(ok_cnt == int'(VEC[v].exp_ok), $sformatf("R3 vec%0d ok pulses", v),
          ok_cnt, int'(VEC[v].exp_ok));
      chk(env == VEC[v].exp_env, $sformatf("R1 vec%0d envelope", v),
          int'(env), int'(VEC[v].exp_env));
    end

    // R6 / R8 / R2: hold and timeout, div 40 sens 0 -> hi 41
    do_reset();
    div = 12'd40; sens = 4'd0;
    drive(1'b0);
    emit(40, 2);                              // now in cycle k+1
    chk(env == 1'b1 && ok == 1'b1, "R6 env with ok", {env, ok}, 3);
    repeat (20) drive(1'b0);
    smp();
    chk(env == 1'b1, "R6 env held mid period", int'(env), 1);
    repeat (21) drive(1'b0);                  // cycle k+42
    smp();
    chk(env == 1'b1, "R8 env before timeout", int'(env), 1);
    drive(1'b0);                              // cycle k+43
    smp();
    chk(env == 1'b0, "R8 env after timeout", int'(env), 0);
    drive(1'b1); drive(1'b0); smp();
    chk(ok == 1'b0, "R2 first edge after timeout", int'(ok), 0);
    repeat (38) drive(1'b0);
    drive(1'b1); drive(1'b0); smp();
    chk(ok == 1'b1 && env == 1'b1, "R2 recovery after timeout", {ok, env}, 3);

    // R7 bad period then re-reference
    do_reset();
    div = 12'd40; sens = 4'd0;
    drive(1'b0);
    emit(40, 2);
    repeat (18) drive(1'b0);
    drive(1'b1); drive(1'b0); smp();          // 20-cycle period
    chk(env == 1'b0 && ok == 1'b0, "R7 short period drops env", {env, ok}, 0);
    repeat (38) drive(1'b0);
    drive(1'b1); drive(1'b0); smp();
    chk(env == 1'b1 && ok == 1'b1, "R7 new reference accepted", {env, ok}, 3);

    summary();
    $finish;
  end
endmodule